// File: doc/BRIEF.md
# Signed Halfword Multiply-Accumulate Unit

This execute-stage unit for a 32-bit core computes one signed 16x16 multiply-accumulate per accepted strobe. The instruction word selects, for each of the two multiplicand registers, whether its low or high halfword is used. The chosen halfwords are sign-extended and multiplied, and the full 32-bit accumulator value is added to the product. The sum wraps and is never saturated. The sticky overflow flag supplied by the core is passed through. It is set when the accumulate addition overflows as a signed operation, and it is never cleared.

The register file, the condition check and hazard control sit outside the unit. The core hands over the three operand values, the current sticky flag and a core-generation select. One cycle later it takes back a destination index, the result, a write enable, the new sticky flag and an illegal-encoding indication.

Top module: `smla_unit`

## Requirements
- R1: An instruction is recognised when bits [27:20] equal 8'b00010000, bit 7 is 1, bit 4 is 0 and `v5_en_i` is 1. Bits [31:28] are ignored.
- R2: The destination index is taken from bits [19:16] and appears on `rd_idx_o`. The accumulator operand is from bits [15:12], the Rs operand from bits [11:8] and the Rm operand from bits [3:0]. The core reads these registers from the instruction before driving the operand values.
- R3: Instruction bit 5 selects the Rm halfword and bit 6 selects the Rs halfword. A value of 0 selects bits [15:0] and a value of 1 selects bits [31:16]. Each selected halfword is sign-extended before the multiply.
- R4: `result_o` equals the signed 32-bit product plus `rn_val_i`, modulo 2^32, without saturation.
- R5: `q_o` becomes 1 when the product and `rn_val_i` have the same sign and the sum's sign differs from it. Otherwise `q_o` equals the `q_i` that came with the instruction, so the flag is never cleared.
- R6: A destination index of 15 produces no write, `illegal_o` stays low and `q_o` equals `q_i`.
- R7: An accepted strobe with an unrecognised pattern, or with `v5_en_i` low, gives `illegal_o` = 1, `wr_en_o` = 0 and `q_o` = `q_i` one cycle later.
- R8: All outputs are registered and valid one cycle after `valid_i`. `wr_en_o` and `illegal_o` are low in a cycle that follows no strobe.
- R9: While `rst_ni` is low, `wr_en_o`, `illegal_o`, `q_o`, `rd_idx_o` and `result_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| v5_en_i | input | 1 | 1 = core generation supports the operation |
| instr_i | input | 32 | Instruction word |
| rm_val_i | input | 32 | First multiplicand register value |
| rs_val_i | input | 32 | Second multiplicand register value |
| rn_val_i | input | 32 | Accumulator register value |
| q_i | input | 1 | Current sticky overflow flag |
| wr_en_o | output | 1 | Destination write enable |
| rd_idx_o | output | 4 | Destination register index |
| result_o | output | 32 | Accumulated result |
| q_o | output | 1 | Updated sticky overflow flag |
| illegal_o | output | 1 | Unrecognised encoding or unsupported core |

## Verification
The internal state consists of a single output register stage. Any wrong halfword select, sign extension or carry shows up on `result_o` in the cycle right after the strobe. A flag computed from the wrong sign bits shows up on `q_o` in that same cycle. The vectors use halfwords of both signs, the extreme product 2^30, and sums that cross the sign boundary in both directions. A fault in the sticky logic therefore shows either as a spurious clear or as a missed set. Faults in the destination-15 or generation gating appear as a stray `wr_en_o` pulse one cycle after the offending strobe.

// File: rtl/smla_pkg.sv
package smla_pkg;
  localparam int unsigned IDX_W = 4;
  localparam logic [IDX_W-1:0] PC_IDX = 4'd15;
  localparam logic [7:0] OPC_HI = 8'b0001_0000;

  typedef struct packed {
    logic             legal;
    logic [IDX_W-1:0] rd;
    logic [IDX_W-1:0] rn;
    logic [IDX_W-1:0] rs;
    logic [IDX_W-1:0] rm;
    logic             rm_top;
    logic             rs_top;
  } smla_dec_t;
endpackage

// File: rtl/smla_decode.sv
module smla_decode
  import smla_pkg::*;
(
  input  logic [31:0] instr_i,
  input  logic        v5_en_i,
  output smla_dec_t   dec_o
);
  always_comb begin
    dec_o.legal  = v5_en_i && (instr_i[27:20] == OPC_HI) && instr_i[7] && !instr_i[4];
    dec_o.rd     = instr_i[19:16];
    dec_o.rn     = instr_i[15:12];
    dec_o.rs     = instr_i[11:8];
    dec_o.rm     = instr_i[3:0];
    dec_o.rm_top = instr_i[5];
    dec_o.rs_top = instr_i[6];
  end
endmodule

// File: rtl/smla_half_sel.sv
module smla_half_sel #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0]        val_i,
  input  logic                     top_i,
  output logic signed [DATA_W-1:0] ext_o
);
  localparam int unsigned HALF_W = DATA_W / 2;
  logic [HALF_W-1:0] half;

  always_comb begin
    half  = top_i ? val_i[DATA_W-1:HALF_W] : val_i[HALF_W-1:0];
    ext_o = {{HALF_W{half[HALF_W-1]}}, half};
  end
endmodule

// File: rtl/smla_mac.sv
module smla_mac #(
  parameter int unsigned DATA_W = 32
) (
  input  logic signed [DATA_W-1:0] a_i,
  input  logic signed [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0]        acc_i,
  output logic [DATA_W-1:0]        sum_o,
  output logic                     ovf_o
);
  localparam int unsigned MSB = DATA_W - 1;
  logic signed [DATA_W-1:0] prod;

  // half x half product fits in DATA_W bits; only the add can overflow
  always_comb begin
    prod  = a_i * b_i;
    sum_o = prod + acc_i;
    ovf_o = (prod[MSB] == acc_i[MSB]) && (sum_o[MSB] != prod[MSB]);
  end
endmodule

// File: rtl/smla_unit.sv
module smla_unit
  import smla_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              v5_en_i,
  input  logic [31:0]       instr_i,
  input  logic [DATA_W-1:0] rm_val_i,
  input  logic [DATA_W-1:0] rs_val_i,
  input  logic [DATA_W-1:0] rn_val_i,
  input  logic              q_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic [DATA_W-1:0] result_o,
  output logic              q_o,
  output logic              illegal_o
);
  localparam int unsigned N_OPS = 2;
  localparam int unsigned MSB   = DATA_W - 1;

  smla_dec_t dec;
  logic [DATA_W-1:0]        op_val [N_OPS];
  logic                     op_top [N_OPS];
  logic signed [DATA_W-1:0] op_ext [N_OPS];
  logic [DATA_W-1:0]        sum;
  logic                     ovf;
  logic                     do_write;

  smla_decode u_dec (
    .instr_i (instr_i),
    .v5_en_i (v5_en_i),
    .dec_o   (dec)
  );

  assign op_val[0] = rm_val_i;
  assign op_val[1] = rs_val_i;
  assign op_top[0] = dec.rm_top;
  assign op_top[1] = dec.rs_top;

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    smla_half_sel #(.DATA_W(DATA_W)) u_sel (
      .val_i (op_val[g]),
      .top_i (op_top[g]),
      .ext_o (op_ext[g])
    );
  end

  smla_mac #(.DATA_W(DATA_W)) u_mac (
    .a_i   (op_ext[0]),
    .b_i   (op_ext[1]),
    .acc_i (rn_val_i),
    .sum_o (sum),
    .ovf_o (ovf)
  );

  assign do_write = dec.legal && (dec.rd != PC_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o   <= 1'b0;
      illegal_o <= 1'b0;
      rd_idx_o  <= '0;
      result_o  <= '0;
      q_o       <= 1'b0;
    end else begin
      wr_en_o   <= valid_i && do_write;
      illegal_o <= valid_i && !dec.legal;
      if (valid_i) begin
        rd_idx_o <= dec.rd;
        result_o <= sum;
        q_o      <= q_i | (do_write & ovf);
      end
    end
  end

  // R8
  wr_needs_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o || illegal_o) |-> $past(valid_i));

  // R7
  wr_ill_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_en_o, illegal_o}));

  // R6
  pc_dest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[19:16] == PC_IDX) |=> (!wr_en_o && q_o == $past(q_i)));

  // R7
  old_core_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !v5_en_i) |=> (illegal_o && !wr_en_o));

  // R5
  q_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && q_i) |=> q_o);

  // R5
  q_set_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && q_o && !$past(q_i)) |-> (result_o[MSB] != $past(rn_val_i[MSB])));

  // R2
  rd_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (rd_idx_o == $past(instr_i[19:16])));
endmodule

// File: tb/smla_unit_tb_top.sv
`timescale 1ns/1ps
module smla_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        v5_en_i = 1'b1;
  logic [31:0] instr_i = '0;
  logic [31:0] rm_val_i = '0, rs_val_i = '0, rn_val_i = '0;
  logic        q_i = 1'b0;
  logic        wr_en_o, q_o, illegal_o;
  logic [3:0]  rd_idx_o;
  logic [31:0] result_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  smla_unit dut_i (
    .clk_i, .rst_ni, .valid_i, .v5_en_i, .instr_i, .rm_val_i, .rs_val_i,
    .rn_val_i, .q_i, .wr_en_o, .rd_idx_o, .result_o, .q_o, .illegal_o
  );

  typedef struct packed {
    logic [3:0]  cond;
    logic [3:0]  rd;
    logic        rm_top;
    logic        rs_top;
    logic [31:0] rm;
    logic [31:0] rs;
    logic [31:0] rn;
    logic        q;
    logic        v5;
    logic        bad;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{4'hE, 4'd1, 1'b0, 1'b0, 32'h0003_0005, 32'h0007_FFFE, 32'd100,      1'b0, 1'b1, 1'b0},
    '{4'h0, 4'd2, 1'b0, 1'b1, 32'h1234_8000, 32'h8000_0001, 32'h4000_0000, 1'b0, 1'b1, 1'b0},
    '{4'hE, 4'd3, 1'b1, 1'b0, 32'hFFFF_0000, 32'h0000_0010, 32'h8000_0000, 1'b0, 1'b1, 1'b0},
    '{4'h5, 4'd4, 1'b1, 1'b1, 32'h0002_7FFF, 32'h0003_8000, 32'd7,         1'b1, 1'b1, 1'b0},
    '{4'hE, 4'd15,1'b0, 1'b1, 32'h1234_8000, 32'h8000_0001, 32'h4000_0000, 1'b0, 1'b1, 1'b0},
    '{4'hE, 4'd5, 1'b0, 1'b0, 32'h0000_0002, 32'h0000_0003, 32'd1,         1'b0, 1'b0, 1'b0},
    '{4'hE, 4'd6, 1'b0, 1'b0, 32'h0000_0002, 32'h0000_0003, 32'd1,         1'b1, 1'b1, 1'b1},
    '{4'hE, 4'd7, 1'b1, 1'b1, 32'h8000_1111, 32'h7FFF_2222, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0},
    '{4'hE, 4'd8, 1'b0, 1'b1, 32'hABCD_FFFB, 32'h0009_5555, 32'h7FFF_FFF0, 1'b0, 1'b1, 1'b0},
    '{4'hE, 4'd0, 1'b1, 1'b0, 32'h7FFF_0000, 32'h0000_7FFF, 32'h4000_0000, 1'b0, 1'b1, 1'b0},
    '{4'hE, 4'd9, 1'b1, 1'b1, 32'h8000_0000, 32'h8000_0000, 32'h3FFF_FFFF, 1'b0, 1'b1, 1'b0}
  };

  function automatic logic [31:0] mk_instr(vec_t v);
    logic [31:0] w;
    w = {v.cond, 8'b0001_0000, v.rd, 4'd10, 4'd11, 1'b1, v.rs_top, v.rm_top, 1'b0, 4'd12};
    if (v.bad) w[4] = 1'b1;
    return w;
  endfunction

  function automatic logic [31:0] ext16(logic [15:0] h);
    return {{16{h[15]}}, h};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5.0);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] x, y, p, s;
    logic        legal, wr, qe;
    // R9 reset state
    repeat (3) @(negedge clk_i);
    chk("R9 wr_en", {31'b0, wr_en_o}, 32'd0);
    chk("R9 illegal", {31'b0, illegal_o}, 32'd0);
    chk("R9 q", {31'b0, q_o}, 32'd0);
    chk("R9 result", result_o, 32'd0);
    chk("R9 rd_idx", {28'b0, rd_idx_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R8 idle: no strobe, no enables
    chk("R8 idle wr_en", {31'b0, wr_en_o}, 32'd0);
    chk("R8 idle illegal", {31'b0, illegal_o}, 32'd0);

    // back-to-back table walk (R1..R7)
    for (int i = 0; i < NV; i++) begin
      valid_i  = 1'b1;
      instr_i  = mk_instr(VECS[i]);
      rm_val_i = VECS[i].rm;
      rs_val_i = VECS[i].rs;
      rn_val_i = VECS[i].rn;
      q_i      = VECS[i].q;
      v5_en_i  = VECS[i].v5;
      x = ext16(VECS[i].rm_top ? VECS[i].rm[31:16] : VECS[i].rm[15:0]);
      y = ext16(VECS[i].rs_top ? VECS[i].rs[31:16] : VECS[i].rs[15:0]);
      p = 32'($signed(x) * $signed(y));
      s = p + VECS[i].rn;
      legal = VECS[i].v5 && !VECS[i].bad;
      wr = legal && (VECS[i].rd != 4'd15);
      qe = VECS[i].q | (wr && (p[31] == VECS[i].rn[31]) && (s[31] != p[31]));
      @(negedge clk_i);
      chk("R1/R6 wr_en", {31'b0, wr_en_o}, {31'b0, wr});
      chk("R7 illegal", {31'b0, illegal_o}, {31'b0, !legal});
      chk("R5 q", {31'b0, q_o}, {31'b0, qe});
      if (wr) begin
        chk("R2 rd_idx", {28'b0, rd_idx_o}, {28'b0, VECS[i].rd});
        chk("R3/R4 result", result_o, s);
      end
    end

    // R8 strobe dropped: enables fall next cycle
    valid_i = 1'b0;
    @(negedge clk_i);
    chk("R8 drop wr_en", {31'b0, wr_en_o}, 32'd0);
    chk("R8 drop illegal", {31'b0, illegal_o}, 32'd0);

    // R8 one-cycle latency: present with strobe, check only after one edge
    valid_i = 1'b1; v5_en_i = 1'b1; q_i = 1'b0;
    instr_i = {4'hE, 8'b0001_0000, 4'd3, 4'd1, 4'd2, 4'b1000, 4'd4};
    rm_val_i = 32'h0000_0004; rs_val_i = 32'h0000_0005; rn_val_i = 32'd10;
    #1;
    chk("R8 no comb path", {31'b0, wr_en_o}, 32'd0);
    @(negedge clk_i);
    valid_i = 1'b0;
    chk("R8 latency wr_en", {31'b0, wr_en_o}, 32'd1);
    chk("R4 small result", result_o, 32'd30);

    // R1 opcode field mismatch -> illegal
    valid_i = 1'b1;
    instr_i = {4'hE, 8'b0001_0010, 4'd3, 4'd1, 4'd2, 4'b1000, 4'd4};
    @(negedge clk_i);
    valid_i = 1'b0;
    chk("R1 opcode illegal", {31'b0, illegal_o}, 32'd1);
    chk("R1 opcode no write", {31'b0, wr_en_o}, 32'd0);

    // R1 bit 7 cleared -> illegal
    valid_i = 1'b1;
    instr_i = {4'hE, 8'b0001_0000, 4'd3, 4'd1, 4'd2, 4'b0000, 4'd4};
    @(negedge clk_i);
    valid_i = 1'b0;
    chk("R1 bit7 illegal", {31'b0, illegal_o}, 32'd1);

    // R9 asynchronous reset mid-stream
    valid_i = 1'b1;
    instr_i = {4'hE, 8'b0001_0000, 4'd3, 4'd1, 4'd2, 4'b1000, 4'd4};
    q_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    chk("R9 async wr_en", {31'b0, wr_en_o}, 32'd0);
    chk("R9 async q", {31'b0, q_o}, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    finish_run();
  end
endmodule